// File: doc/BRIEF.md
# Weight-Stationary Vector MAC Processing Element

This block is one convolution tile of a larger inference array. Its own buffers are filled through two streaming ports: one for weight words and one for activation vectors. After that it runs a number of parallel lanes, eight by default. Each lane produces one output channel and is a signed dot-product unit over eight input channels, so the default block performs 64 multiply-accumulates per cycle. A weight word holds the weights of every lane for one input-channel group. It is read once and then held for a whole sweep of the P×Q output plane. One activation vector is read every cycle, and all lanes use that same read. Each output position has its own running sum, so partial sums build up over the input-channel groups.

When the sweep ends, the block drains one vector per output position. Each lane's local sum is added to the matching lane of a partial-sum vector coming from the upstream element, and the total is sent downstream. Both cascade ports use valid/ready. A transfer happens on a clock edge where valid and ready are both high. A valid output keeps its data stable until it is accepted. The cascade input is only accepted when the output register is empty or is being emptied in that same cycle, so back-pressure from downstream stalls the element and loses nothing.

Control is plain. A `cfg_load` pulse in idle captures P, Q and the group count G. A `start` pulse opens the fill phase. A one-cycle `done` pulse ends the operation.

Top module: `vmac_pe`

## Requirements
- R1: While reset is held and after it is released, `w_ready`, `a_ready`, `cas_in_ready`, `cas_out_valid` and `done` are all low.
- R2: A `start` pulse in idle raises both fill readies. The weight port accepts exactly G words (addresses 0..G-1, in order). The activation port accepts exactly G·P·Q vectors (address g·P·Q+pos, in order). Outside this fill phase both readies are low, so fill data offered at any other time is ignored.
- R3: Computation begins only after both buffers are complete. It lasts G·P·Q cycles, so `cas_in_ready` first rises G·P·Q+1 cycles after the edge that accepts the final fill item.
- R4: For position pos and lane l, the local sum is Σ over g and c of signed w[g][l][c] × signed a[g·P·Q+pos][c]. Weight byte (l,c) sits at `w_data[(l*8+c)*8 +: 8]` and activation byte c at `a_data[c*8 +: 8]`. Both are 8-bit two's complement.
- R5: A lane's weight vector stays constant for the P·Q consecutive cycles of a sweep. The activation vector changes every cycle and is the same for all lanes.
- R6: Accumulators are 24-bit two's complement and wrap modulo 2^24.
- R7: The output for pos and lane l is (local sum + upstream lane l) mod 2^24, with lane l at bits `[l*24 +: 24]`. Outputs come out in position order 0..P·Q-1, and each appears one cycle after its cascade input is accepted.
- R8: While `cas_out_valid` is high and `cas_out_ready` is low, the output stays valid and its data stays unchanged.
- R9: `cas_in_ready` is high only during the drain phase, and the drain phase accepts exactly P·Q cascade inputs.
- R10: `done` is a single-cycle pulse in the cycle after the last output is accepted. The block then returns to idle and can run another operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Capture P, Q, G (idle only) |
| cfg_p | input | 7 | Output plane width P |
| cfg_q | input | 7 | Output plane height Q |
| cfg_groups | input | 10 | Input-channel group count G |
| start | input | 1 | Begin fill phase (idle only) |
| w_valid | input | 1 | Weight word valid |
| w_ready | output | 1 | Weight word accepted when high with valid |
| w_data | input | 512 | Weight word, all lanes of one group |
| a_valid | input | 1 | Activation vector valid |
| a_ready | output | 1 | Activation vector accepted when high with valid |
| a_data | input | 64 | Activation vector, eight channels |
| cas_in_valid | input | 1 | Upstream partial-sum valid |
| cas_in_ready | output | 1 | Upstream partial-sum accepted |
| cas_in_data | input | 192 | Upstream partial sums, eight 24-bit lanes |
| cas_out_valid | output | 1 | Combined sum valid |
| cas_out_ready | input | 1 | Downstream ready |
| cas_out_data | output | 192 | Combined sums, eight 24-bit lanes |
| done | output | 1 | One-cycle end-of-operation pulse |

## Verification
Each result has a fixed delay after its stimulus. The fill readies rise one cycle after `start`. The drain phase opens G·P·Q+1 cycles after the final fill item is accepted. A combined output appears one cycle after its cascade input is accepted. `done` follows the last output acceptance by one cycle. The bench drives and samples on the falling edge. Within the drain loop it waits a short settle delay after setting `cas_out_ready`, then judges which handshakes fire at the next rising edge. It counts cycles to the exact edge each result is due and compares there. During stalls it also compares every held output against its value in the previous cycle.

// File: rtl/vmac_pkg.sv
package vmac_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_COMP  = 2'd2,
    ST_DRAIN = 2'd3
  } pe_state_e;

endpackage

// File: rtl/vmac_lane.sv
module vmac_lane #(
  parameter int VEC  = 8,
  parameter int OPW  = 8,
  parameter int ACCW = 24
) (
  input  logic [VEC*OPW-1:0] w_vec,
  input  logic [VEC*OPW-1:0] a_vec,
  output logic [ACCW-1:0]    dot
);

  localparam int PW   = 2 * OPW;
  localparam int SUMW = PW + $clog2(VEC) + 1;

  logic signed [PW-1:0] prod [VEC];

  generate
    for (genvar c = 0; c < VEC; c++) begin : g_mul
      logic signed [OPW-1:0] ws;
      logic signed [OPW-1:0] as;
      assign ws = w_vec[c*OPW +: OPW];
      assign as = a_vec[c*OPW +: OPW];
      assign prod[c] = PW'(ws) * PW'(as);
    end
  endgenerate

  logic signed [SUMW-1:0] sum;

  always_comb begin
    sum = '0;
    for (int c = 0; c < VEC; c++) begin
      sum = sum + SUMW'(prod[c]);
    end
  end

  // sign-extend (or keep) into the accumulator width
  logic signed [ACCW-1:0] dot_s;
  assign dot_s = ACCW'(sum);
  assign dot   = dot_s;

endmodule

// File: rtl/vmac_ctrl.sv
module vmac_ctrl
  import vmac_pkg::*;
#(
  parameter int GW  = 10,
  parameter int PQW = 7,
  parameter int WAW = 9,
  parameter int AAW = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_load,
  input  logic [PQW-1:0]  cfg_p,
  input  logic [PQW-1:0]  cfg_q,
  input  logic [GW-1:0]   cfg_groups,
  input  logic            start,
  input  logic            w_fire,
  input  logic            a_fire,
  input  logic            in_fire,
  input  logic            out_fire,
  output pe_state_e       state,
  output logic            w_ready,
  output logic            a_ready,
  output logic [WAW-1:0]  w_wr_addr,
  output logic [AAW-1:0]  a_wr_addr,
  output logic            comp_en,
  output logic [PQW-1:0]  comp_pos,
  output logic            first_grp,
  output logic [AAW-1:0]  a_rd_addr,
  output logic            w_load,
  output logic [WAW-1:0]  w_load_addr,
  output logic            drain_take,
  output logic [PQW-1:0]  drain_pos,
  output logic            done
);

  localparam int TW = GW + PQW;

  logic [PQW-1:0]   p_r, q_r;
  logic [GW-1:0]    g_r;
  logic [2*PQW-1:0] pq_full;
  logic [PQW-1:0]   pq;
  logic [TW-1:0]    tot_act;

  assign pq_full = {{PQW{1'b0}}, p_r} * {{PQW{1'b0}}, q_r};
  assign pq      = pq_full[PQW-1:0];
  assign tot_act = {{PQW{1'b0}}, g_r} * {{GW{1'b0}}, pq};

  logic [GW-1:0]  w_cnt;
  logic [TW-1:0]  a_cnt;
  logic [GW-1:0]  grp;
  logic [TW-1:0]  a_rd;
  logic [PQW-1:0] pos;
  logic [PQW-1:0] issued;
  logic [PQW-1:0] taken;

  logic w_full, a_full, last_pos, last_grp, last_out;
  logic [GW-1:0] grp_next;

  assign w_full   = (w_cnt == g_r);
  assign a_full   = (a_cnt == tot_act);
  assign last_pos = (pos == pq - 1'b1);
  assign last_grp = (grp == g_r - 1'b1);
  assign last_out = (taken == pq - 1'b1);
  assign grp_next = grp + 1'b1;

  assign w_ready     = (state == ST_LOAD) && !w_full;
  assign a_ready     = (state == ST_LOAD) && !a_full;
  assign w_wr_addr   = w_cnt[WAW-1:0];
  assign a_wr_addr   = a_cnt[AAW-1:0];
  assign comp_en     = (state == ST_COMP);
  assign comp_pos    = pos;
  assign first_grp   = (grp == '0);
  assign a_rd_addr   = a_rd[AAW-1:0];
  assign drain_take  = (state == ST_DRAIN) && (issued != pq);
  assign drain_pos   = issued;

  // weight word fetched once before each sweep, never inside one
  assign w_load      = ((state == ST_LOAD) && w_full && a_full) ||
                       ((state == ST_COMP) && last_pos && !last_grp);
  assign w_load_addr = (state == ST_LOAD) ? '0 : grp_next[WAW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      p_r    <= '0;
      q_r    <= '0;
      g_r    <= '0;
      w_cnt  <= '0;
      a_cnt  <= '0;
      grp    <= '0;
      a_rd   <= '0;
      pos    <= '0;
      issued <= '0;
      taken  <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (cfg_load) begin
            p_r <= cfg_p;
            q_r <= cfg_q;
            g_r <= cfg_groups;
          end else if (start) begin
            w_cnt <= '0;
            a_cnt <= '0;
            state <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (w_fire) w_cnt <= w_cnt + 1'b1;
          if (a_fire) a_cnt <= a_cnt + 1'b1;
          if (w_full && a_full) begin
            grp   <= '0;
            pos   <= '0;
            a_rd  <= '0;
            state <= ST_COMP;
          end
        end
        ST_COMP: begin
          a_rd <= a_rd + 1'b1;
          if (last_pos) begin
            pos <= '0;
            if (last_grp) begin
              issued <= '0;
              taken  <= '0;
              state  <= ST_DRAIN;
            end else begin
              grp <= grp_next;
            end
          end else begin
            pos <= pos + 1'b1;
          end
        end
        ST_DRAIN: begin
          if (in_fire) issued <= issued + 1'b1;
          if (out_fire) begin
            taken <= taken + 1'b1;
            if (last_out) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_COMP_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_COMP) |-> (w_full && a_full)) else $error("compute before fill");   // R3

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done longer than one cycle");                     // R10

  AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (state == ST_IDLE)) else $error("done outside idle");                 // R10

endmodule

// File: rtl/vmac_accum.sv
module vmac_accum #(
  parameter int LANES  = 8,
  parameter int ACCW   = 24,
  parameter int MAX_PQ = 64,
  parameter int PQW    = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  comp_en,
  input  logic [PQW-1:0]        comp_pos,
  input  logic                  first_grp,
  input  logic [LANES*ACCW-1:0] dot_all,
  input  logic                  drain_take,
  input  logic [PQW-1:0]        drain_pos,
  input  logic                  cas_in_valid,
  output logic                  cas_in_ready,
  input  logic [LANES*ACCW-1:0] cas_in_data,
  output logic                  cas_out_valid,
  input  logic                  cas_out_ready,
  output logic [LANES*ACCW-1:0] cas_out_data
);

  localparam int CASW = LANES * ACCW;
  localparam int PAW  = (MAX_PQ > 1) ? $clog2(MAX_PQ) : 1;

  logic [CASW-1:0] acc_mem [MAX_PQ];
  logic [CASW-1:0] acc_old, acc_new, drain_old, drain_sum;
  logic [PAW-1:0]  c_addr, d_addr;

  assign c_addr    = comp_pos[PAW-1:0];
  assign d_addr    = drain_pos[PAW-1:0];
  assign acc_old   = acc_mem[c_addr];
  assign drain_old = acc_mem[d_addr];

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane_add
      logic [ACCW-1:0] base;
      assign base = first_grp ? '0 : acc_old[l*ACCW +: ACCW];
      assign acc_new[l*ACCW +: ACCW]   = base + dot_all[l*ACCW +: ACCW];
      assign drain_sum[l*ACCW +: ACCW] = drain_old[l*ACCW +: ACCW] +
                                         cas_in_data[l*ACCW +: ACCW];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (comp_en) acc_mem[c_addr] <= acc_new;
  end

  logic in_fire;
  assign cas_in_ready = drain_take && (!cas_out_valid || cas_out_ready);
  assign in_fire      = cas_in_valid && cas_in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cas_out_valid <= 1'b0;
      cas_out_data  <= '0;
    end else if (in_fire) begin
      cas_out_valid <= 1'b1;
      cas_out_data  <= drain_sum;
    end else if (cas_out_ready) begin
      cas_out_valid <= 1'b0;
    end
  end

  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_out_valid && !cas_out_ready) |=> (cas_out_valid && $stable(cas_out_data)))
    else $error("output changed under back-pressure");                              // R8

  AST_NO_DRAIN_DURING_COMP: assert property (@(posedge clk) disable iff (!rst_n)
    comp_en |-> !cas_in_ready) else $error("cascade input open during compute");     // R9

endmodule

// File: rtl/vmac_pe.sv
module vmac_pe
  import vmac_pkg::*;
#(
  parameter int LANES      = 8,
  parameter int VEC        = 8,
  parameter int OPW        = 8,
  parameter int ACCW       = 24,
  parameter int WBUF_WORDS = 32768 / (LANES * VEC * OPW / 8),
  parameter int ABUF_WORDS = 8192 / (VEC * OPW / 8),
  parameter int MAX_PQ     = 64,
  localparam int WWORD     = LANES * VEC * OPW,
  localparam int AWORD     = VEC * OPW,
  localparam int CASW      = LANES * ACCW,
  localparam int PQW       = $clog2(MAX_PQ + 1),
  localparam int GW        = $clog2(WBUF_WORDS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic [PQW-1:0]   cfg_p,
  input  logic [PQW-1:0]   cfg_q,
  input  logic [GW-1:0]    cfg_groups,
  input  logic             start,
  input  logic             w_valid,
  output logic             w_ready,
  input  logic [WWORD-1:0] w_data,
  input  logic             a_valid,
  output logic             a_ready,
  input  logic [AWORD-1:0] a_data,
  input  logic             cas_in_valid,
  output logic             cas_in_ready,
  input  logic [CASW-1:0]  cas_in_data,
  output logic             cas_out_valid,
  input  logic             cas_out_ready,
  output logic [CASW-1:0]  cas_out_data,
  output logic             done
);

  localparam int WAW = $clog2(WBUF_WORDS);
  localparam int AAW = $clog2(ABUF_WORDS);

  pe_state_e      state;
  logic [WAW-1:0] w_wr_addr, w_load_addr;
  logic [AAW-1:0] a_wr_addr, a_rd_addr;
  logic           comp_en, first_grp, w_load, drain_take;
  logic [PQW-1:0] comp_pos, drain_pos;
  logic           w_fire, a_fire, in_fire, out_fire;

  assign w_fire   = w_valid && w_ready;
  assign a_fire   = a_valid && a_ready;
  assign in_fire  = cas_in_valid && cas_in_ready;
  assign out_fire = cas_out_valid && cas_out_ready;

  vmac_ctrl #(.GW(GW), .PQW(PQW), .WAW(WAW), .AAW(AAW)) i_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_load    (cfg_load),
    .cfg_p       (cfg_p),
    .cfg_q       (cfg_q),
    .cfg_groups  (cfg_groups),
    .start       (start),
    .w_fire      (w_fire),
    .a_fire      (a_fire),
    .in_fire     (in_fire),
    .out_fire    (out_fire),
    .state       (state),
    .w_ready     (w_ready),
    .a_ready     (a_ready),
    .w_wr_addr   (w_wr_addr),
    .a_wr_addr   (a_wr_addr),
    .comp_en     (comp_en),
    .comp_pos    (comp_pos),
    .first_grp   (first_grp),
    .a_rd_addr   (a_rd_addr),
    .w_load      (w_load),
    .w_load_addr (w_load_addr),
    .drain_take  (drain_take),
    .drain_pos   (drain_pos),
    .done        (done)
  );

  // local operand stores
  logic [WWORD-1:0] wbuf [WBUF_WORDS];
  logic [AWORD-1:0] abuf [ABUF_WORDS];
  logic [WWORD-1:0] w_hold;
  logic [AWORD-1:0] a_cur;

  always_ff @(posedge clk) begin
    if (w_fire) wbuf[w_wr_addr] <= w_data;
    if (a_fire) abuf[a_wr_addr] <= a_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      w_hold <= '0;
    else if (w_load) w_hold <= wbuf[w_load_addr];
  end

  assign a_cur = abuf[a_rd_addr];

  logic [CASW-1:0] dot_all;

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      vmac_lane #(.VEC(VEC), .OPW(OPW), .ACCW(ACCW)) i_lane (
        .w_vec (w_hold[l*VEC*OPW +: VEC*OPW]),
        .a_vec (a_cur),
        .dot   (dot_all[l*ACCW +: ACCW])
      );
    end
  endgenerate

  vmac_accum #(.LANES(LANES), .ACCW(ACCW), .MAX_PQ(MAX_PQ), .PQW(PQW)) i_accum (
    .clk           (clk),
    .rst_n         (rst_n),
    .comp_en       (comp_en),
    .comp_pos      (comp_pos),
    .first_grp     (first_grp),
    .dot_all       (dot_all),
    .drain_take    (drain_take),
    .drain_pos     (drain_pos),
    .cas_in_valid  (cas_in_valid),
    .cas_in_ready  (cas_in_ready),
    .cas_in_data   (cas_in_data),
    .cas_out_valid (cas_out_valid),
    .cas_out_ready (cas_out_ready),
    .cas_out_data  (cas_out_data)
  );

  AST_WEIGHT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (comp_en && comp_pos != '0) |-> $stable(w_hold))
    else $error("weight vector changed inside a sweep");                             // R5

  AST_CASIN_ONLY_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    cas_in_ready |-> (state == ST_DRAIN)) else $error("cascade input outside drain"); // R9

  AST_FILL_CLOSED_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    comp_en |-> (!w_ready && !a_ready)) else $error("fill open during compute");     // R2

endmodule

// File: tb/test_vmac_pe.sv
`timescale 1ns/1ps
module test_vmac_pe;

  localparam int L = 8, V = 8;
  localparam int WWORD = 512, AWORD = 64, CASW = 192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic             cfg_load = 0, start = 0;
  logic [6:0]       cfg_p = 0, cfg_q = 0;
  logic [9:0]       cfg_groups = 0;
  logic             w_valid = 0, a_valid = 0, cas_in_valid = 0, cas_out_ready = 0;
  logic [WWORD-1:0] w_data = '0;
  logic [AWORD-1:0] a_data = '0;
  logic [CASW-1:0]  cas_in_data = '0;
  logic             w_ready, a_ready, cas_in_ready, cas_out_valid, done;
  logic [CASW-1:0]  cas_out_data;

  vmac_pe i_vmac_pe (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_p(cfg_p), .cfg_q(cfg_q),
    .cfg_groups(cfg_groups), .start(start),
    .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data),
    .a_valid(a_valid), .a_ready(a_ready), .a_data(a_data),
    .cas_in_valid(cas_in_valid), .cas_in_ready(cas_in_ready), .cas_in_data(cas_in_data),
    .cas_out_valid(cas_out_valid), .cas_out_ready(cas_out_ready),
    .cas_out_data(cas_out_data), .done(done)
  );

  int checks = 0;
  int failures = 0;

  task automatic chk(input bit ok, input string req, input logic [255:0] act,
                     input logic [255:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // operand generators (seed 0 = extreme values)
  function automatic int wb(int seed, int g, int l, int c);
    if (seed == 0) return -128;
    return ((seed*37 + g*53 + l*19 + c*7 + g*l*3) % 256) - 128;
  endfunction
  function automatic int ab(int seed, int idx, int c);
    if (seed == 0) return -128;
    return ((seed*11 + idx*29 + c*13 + idx*c) % 256) - 128;
  endfunction
  function automatic int cs(int seed, int pos, int l);
    if (seed == 0) return 0;
    return ((seed*917 + pos*611 + l*97) % 4001) - 2000;
  endfunction
  function automatic logic [CASW-1:0] expect_vec(int pq, int g_n, int seed, int pos);
    logic [CASW-1:0] r;
    for (int l = 0; l < L; l++) begin
      int s = 0;
      for (int g = 0; g < g_n; g++)
        for (int c = 0; c < V; c++)
          s += wb(seed, g, l, c) * ab(seed, g*pq + pos, c);
      s += cs(seed, pos, l);
      r[l*24 +: 24] = 24'(s);
    end
    return r;
  endfunction

  // table: P, Q, G, seed
  localparam int NCASE = 5;
  localparam int TBL [NCASE][4] = '{
    '{2, 2, 2, 5},
    '{3, 1, 3, 9},
    '{1, 1, 1, 2},
    '{4, 4, 2, 11},
    '{1, 1, 64, 0}
  };

  task automatic run_case(input int p, input int q, input int g_n, input int seed);
    int pq = p * q;
    int n;
    int idx_in = 0;
    int n_out = 0;
    int k = 0;
    bit prev_stall = 0;
    logic [CASW-1:0] prev_data = '0;
    string tag = (seed == 0) ? "R6" : "R4 R5 R7";

    @(negedge clk);
    cfg_p = 7'(p); cfg_q = 7'(q); cfg_groups = 10'(g_n); cfg_load = 1;
    @(negedge clk);
    cfg_load = 0; start = 1;
    @(negedge clk);
    start = 0;
    chk(w_ready && a_ready, "R2 fill open after start", {w_ready, a_ready}, 2'b11);
    chk(!cas_in_ready, "R9 cascade closed in fill", cas_in_ready, 0);

    for (int g = 0; g < g_n; g++) begin
      logic [WWORD-1:0] wd = '0;
      for (int l = 0; l < L; l++)
        for (int c = 0; c < V; c++)
          wd[(l*V+c)*8 +: 8] = 8'(wb(seed, g, l, c));
      w_data = wd; w_valid = 1;
      while (!w_ready) @(negedge clk);
      @(negedge clk);
    end
    w_valid = 0;
    chk(!w_ready, "R2 weight port closes after G words", w_ready, 0);

    for (int i = 0; i < g_n*pq; i++) begin
      logic [AWORD-1:0] ad = '0;
      for (int c = 0; c < V; c++) ad[c*8 +: 8] = 8'(ab(seed, i, c));
      a_data = ad; a_valid = 1;
      while (!a_ready) begin
        @(negedge clk);
      end
      if (i == g_n*pq - 1) break;
      @(negedge clk);
    end
    // final activation fires at the next rising edge
    @(negedge clk);
    a_valid = 0;
    n = 0;
    chk(!a_ready, "R2 activation port closes after G*P*Q", a_ready, 0);
    while (!cas_in_ready && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(n == g_n*pq + 1, "R3 drain opens after compute", n, g_n*pq + 1);

    do begin
      bit in_f, out_f;
      if (k != 0) @(negedge clk);
      cas_out_ready = (seed == 0) ? 1'b1 : (((k + seed) % 3) != 0);
      cas_in_valid = (idx_in < pq);
      for (int l = 0; l < L; l++)
        cas_in_data[l*24 +: 24] = 24'(cs(seed, idx_in, l));
      #1;
      if (prev_stall)
        chk(cas_out_valid && cas_out_data == prev_data, "R8 held under back-pressure",
            cas_out_data, prev_data);
      in_f  = cas_in_valid && cas_in_ready;
      out_f = cas_out_valid && cas_out_ready;
      if (out_f) begin
        logic [CASW-1:0] e = expect_vec(pq, g_n, seed, n_out);
        chk(cas_out_data == e, tag, cas_out_data, e);
        n_out++;
      end
      prev_stall = cas_out_valid && !cas_out_ready;
      prev_data  = cas_out_data;
      if (in_f) idx_in++;
      k++;
    end while (n_out < pq && k < 5000);
    chk(idx_in == pq, "R9 exactly P*Q cascade inputs", idx_in, pq);
    cas_in_valid = 0;

    @(negedge clk);
    chk(done && !cas_out_valid, "R10 done after last output", {done, cas_out_valid}, 2'b10);
    @(negedge clk);
    chk(!done, "R10 done lasts one cycle", done, 0);
    chk(!w_ready && !a_ready && !cas_in_ready, "R2 ports closed in idle",
        {w_ready, a_ready, cas_in_ready}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!w_ready && !a_ready && !cas_in_ready && !cas_out_valid && !done,
        "R1 reset state", {w_ready, a_ready, cas_in_ready, cas_out_valid, done}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!w_ready && !a_ready && !cas_in_ready && !cas_out_valid && !done,
        "R1 idle after reset", {w_ready, a_ready, cas_in_ready, cas_out_valid, done}, 0);

    for (int t = 0; t < NCASE; t++)
      run_case(TBL[t][0], TBL[t][1], TBL[t][2], TBL[t][3]);

    // fill data offered in idle is refused
    w_valid = 1; a_valid = 1; w_data = '1; a_data = '1;
    repeat (4) begin
      @(negedge clk);
      chk(!w_ready && !a_ready, "R2 fill ignored in idle", {w_ready, a_ready}, 0);
    end
    w_valid = 0; a_valid = 0;

    // back-to-back rerun still correct after the refused traffic
    run_case(2, 3, 1, 7);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule